// File: doc/BRIEF.md
# Asynchronous HDLC Frame Receiver with Descriptor Ring

This block accepts an octet stream that has already been taken out of its character framing, one byte per cycle on a valid strobe. It finds frame boundaries marked by the flag octet 0x7E, undoes the transparency escape, and runs a 16-bit frame check over every decoded byte. Decoded bytes, including the two received check bytes, are written into a local byte RAM. The RAM is divided into equal fixed-size buffers, one for each entry of a small ring of receive descriptors.

Software prepares the ring by arming descriptors. Each arm sets the empty bit and chooses a continuous-mode bit. A frame longer than one buffer carries on into the next armed descriptor. When the frame closes, the block writes four things into the final descriptor: the total frame length, a last bit, a check-error bit and an abort bit. It then raises a one-cycle frame-received pulse. The closing flag of one frame can also serve as the opening flag of the next. Descriptor fields and buffer bytes can be read back through registered read ports.

Top module: `hdlc_rx_ring`

## Requirements
- R1: After reset the receiver hunts for a flag. Data bytes received before the first 0x7E are ignored: no byte is stored, no descriptor changes and no pulse is raised.
- R2: A decoded data byte is stored only if its target descriptor has the empty bit set. Otherwise `rx_busy` pulses for one cycle, the descriptor pointer parks on the refused descriptor, and all data up to the next 0x7E is dropped. Once that descriptor is armed, the next frame is stored there.
- R3: Byte i of a frame goes to buffer address `desc*BUF_BYTES + (i mod BUF_BYTES)`. When a buffer fills, that descriptor's empty bit is cleared and its length becomes BUF_BYTES. The next byte goes to the following descriptor (wrapping from NUM_DESC-1 to 0) at offset 0.
- R4: The escape octet 0x7D is removed. The byte after it is XORed with 0x20 before it is stored and before it enters the check. This applies to any byte, not just 0x7E and 0x7D.
- R5: The check is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, taken over all decoded bytes including the two check bytes. The check-error bit is set exactly when the result is not 0xF0B8.
- R6: When a frame closes, its final descriptor receives the total byte count (check bytes included) and the last bit set. The check bytes are stored in the buffer like any other byte.
- R7: When a frame closes normally, the final descriptor's empty bit is cleared only if its continuous-mode bit is 0. A buffer filled to capacity is cleared anyway, by R3. `rx_frame` pulses for exactly one cycle per closed frame.
- R8: A 0x7E that closes a frame also opens the next one. Data right after it starts a new frame in the next descriptor.
- R9: The pair 0x7D 0x7E closes the partial frame with the abort bit set, the check-error bit clear and the length so far. `rx_frame` still pulses.
- R10: An arm (`sw_arm`) sets the empty bit, loads the continuous-mode bit, and clears the last, check-error, abort and length fields of the chosen descriptor.
- R11: Reset clears every descriptor (not empty), sets the pointer to descriptor 0 and holds `rx_frame` and `rx_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Received octet |
| sw_arm | input | 1 | Arm the descriptor given by sw_idx |
| sw_idx | input | IDX_W | Descriptor to arm |
| sw_cm | input | 1 | Continuous-mode bit loaded on arm |
| rd_idx | input | IDX_W | Descriptor to read back |
| rd_empty | output | 1 | Empty bit (one cycle after rd_idx) |
| rd_cm | output | 1 | Continuous-mode bit |
| rd_last | output | 1 | Last bit |
| rd_crc_err | output | 1 | Check-error bit |
| rd_abort | output | 1 | Abort bit |
| rd_len | output | 16 | Length field |
| buf_raddr | input | ADDR_W | Buffer RAM read address |
| buf_rdata | output | 8 | Buffer RAM byte (one cycle after buf_raddr) |
| rx_frame | output | 1 | Frame-received pulse |
| rx_busy | output | 1 | No empty descriptor pulse |

## Verification
The hardest cases to reach from the ports involve the spill boundary. One is a frame whose length is an exact multiple of the buffer size, which leaves the full buffer as the final descriptor while continuous mode is set. Another is a spill that wraps the ring. Random payload lengths spanning one to three buffers, with random continuous-mode bits on the final descriptor, reach both cases, and a directed eight-byte frame pins down the exact-fill case. The refusal path is reached on purpose by sending a frame to a descriptor that was used and never re-armed. The bench then arms that descriptor and checks that the following frame lands in it.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [7:0]  ESC_OCTET   = 8'h7D;
  localparam logic [7:0]  ESC_MASK    = 8'h20;
  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam int          LEN_W       = 16;

  typedef enum logic [1:0] {RX_HUNT, RX_OPEN, RX_FRAME, RX_DROP} rx_state_e;

  typedef struct packed {
    logic             empty;
    logic             cm;
    logic             last;
    logic             crc_err;
    logic             abort;
    logic [LEN_W-1:0] len;
  } desc_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_deesc.sv
module hdlc_rx_deesc
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       o_data_v,
  output logic [7:0] o_data,
  output logic       o_flag,
  output logic       o_abort
);
  logic esc;

  always_ff @(posedge clk) begin
    o_data_v <= 1'b0;
    o_flag   <= 1'b0;
    o_abort  <= 1'b0;
    if (rst) begin
      esc    <= 1'b0;
      o_data <= '0;
    end else if (in_valid) begin
      if (in_byte == FLAG_OCTET) begin
        esc <= 1'b0;
        if (esc) o_abort <= 1'b1;
        else     o_flag  <= 1'b1;
      end else if (in_byte == ESC_OCTET && !esc) begin
        esc <= 1'b1;
      end else begin
        esc      <= 1'b0;
        o_data_v <= 1'b1;
        o_data   <= esc ? (in_byte ^ ESC_MASK) : in_byte;
      end
    end
  end

  // R4: the escape octet itself never produces an event
  assert_escape_swallowed_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_byte == ESC_OCTET && !esc) |=> !(o_data_v || o_flag || o_abort));

  // R4: escaped byte is delivered with the mask applied
  assert_unescape_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc && in_byte != FLAG_OCTET) |=> (o_data_v && o_data == ($past(in_byte) ^ ESC_MASK)));
endmodule

// File: rtl/hdlc_rx_bytebuf.sv
module hdlc_rx_bytebuf #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hdlc_rx_ring.sv
module hdlc_rx_ring
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int BUF_BYTES = 8,
  localparam int IDX_W  = $clog2(NUM_DESC),
  localparam int ADDR_W = $clog2(NUM_DESC * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              sw_arm,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_cm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_empty,
  output logic              rd_cm,
  output logic              rd_last,
  output logic              rd_crc_err,
  output logic              rd_abort,
  output logic [15:0]       rd_len,
  input  logic [ADDR_W-1:0] buf_raddr,
  output logic [7:0]        buf_rdata,
  output logic              rx_frame,
  output logic              rx_busy
);
  localparam int FILL_W = $clog2(BUF_BYTES + 1);
  localparam int DEPTH  = NUM_DESC * BUF_BYTES;
  localparam logic [FILL_W-1:0] FULL = FILL_W'(BUF_BYTES);

  logic       ev_data, ev_flag, ev_abort;
  logic [7:0] ev_byte;

  hdlc_rx_deesc u_deesc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .o_data_v(ev_data), .o_data(ev_byte), .o_flag(ev_flag), .o_abort(ev_abort)
  );

  rx_state_e         state;
  desc_t             desc [NUM_DESC];
  desc_t             rd_q;
  logic [IDX_W-1:0]  cur;
  logic [FILL_W-1:0] fill;
  logic [LEN_W-1:0]  flen;
  logic [15:0]       crc;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NUM_DESC - 1)) ? '0 : i + 1'b1;
  endfunction

  logic              in_frame, accepting, spill, tgt_ok, store, refuse;
  logic [IDX_W-1:0]  tgt;
  logic [FILL_W-1:0] off;
  logic [ADDR_W-1:0] ram_addr;
  logic [15:0]       crc_next;

  always_comb begin
    in_frame  = (state == RX_FRAME);
    accepting = ev_data && (state == RX_OPEN || in_frame);
    spill     = in_frame && (fill == FULL);
    tgt       = spill ? wrap_inc(cur) : cur;
    off       = (in_frame && !spill) ? fill : '0;
    tgt_ok    = desc[tgt].empty;
    store     = accepting && tgt_ok;
    refuse    = accepting && !tgt_ok;
    ram_addr  = ADDR_W'(tgt) * ADDR_W'(BUF_BYTES) + ADDR_W'(off);
    crc_next  = crc16_step(in_frame ? crc : CRC_INIT, ev_byte);
  end

  hdlc_rx_bytebuf #(.DEPTH(DEPTH), .AW(ADDR_W)) u_buf (
    .clk(clk), .we(store), .waddr(ram_addr), .wdata(ev_byte),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    rx_frame <= 1'b0;
    rx_busy  <= 1'b0;
    rd_q     <= desc[rd_idx];
    if (rst) begin
      state <= RX_HUNT;
      cur   <= '0;
      fill  <= '0;
      flen  <= '0;
      crc   <= CRC_INIT;
      for (int i = 0; i < NUM_DESC; i++) desc[i] <= '0;
    end else begin
      if (sw_arm) begin
        desc[sw_idx]       <= '0;
        desc[sw_idx].empty <= 1'b1;
        desc[sw_idx].cm    <= sw_cm;
      end
      if (ev_flag || ev_abort) begin
        if (in_frame) begin
          desc[cur].last    <= 1'b1;
          desc[cur].len     <= flen;
          desc[cur].abort   <= ev_abort;
          desc[cur].crc_err <= !ev_abort && (crc != CRC_RESIDUE);
          if (!desc[cur].cm) desc[cur].empty <= 1'b0;
          cur      <= wrap_inc(cur);
          rx_frame <= 1'b1;
        end
        state <= RX_OPEN;
        fill  <= '0;
      end else if (store) begin
        cur   <= tgt;
        fill  <= off + 1'b1;
        flen  <= in_frame ? flen + 1'b1 : LEN_W'(1);
        crc   <= crc_next;
        state <= RX_FRAME;
        if (off == '0) begin
          desc[tgt].last    <= 1'b0;
          desc[tgt].abort   <= 1'b0;
          desc[tgt].crc_err <= 1'b0;
        end
        if (off + 1'b1 == FULL) begin
          desc[tgt].empty <= 1'b0;
          desc[tgt].len   <= LEN_W'(BUF_BYTES);
        end
      end else if (refuse) begin
        cur     <= tgt;
        rx_busy <= 1'b1;
        state   <= RX_DROP;
      end
    end
  end

  assign rd_empty   = rd_q.empty;
  assign rd_cm      = rd_q.cm;
  assign rd_last    = rd_q.last;
  assign rd_crc_err = rd_q.crc_err;
  assign rd_abort   = rd_q.abort;
  assign rd_len     = rd_q.len;

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL);

  assert_busy_drops_R2: assert property (@(posedge clk) disable iff (rst)
    rx_busy |-> (state == RX_DROP && !rx_frame));

  assert_pulse_on_delim_R7: assert property (@(posedge clk) disable iff (rst)
    rx_frame |-> $past(ev_flag || ev_abort));

  assert_close_marks_last_R6: assert property (@(posedge clk) disable iff (rst)
    rx_frame |-> desc[$past(cur)].last);
endmodule

// File: tb/test_hdlc_rx_ring.sv
`timescale 1ns/1ps
module test_hdlc_rx_ring;
  localparam int NUM = 4;
  localparam int BUF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, in_valid = 1'b0, sw_arm = 1'b0, sw_cm = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] sw_idx = '0, rd_idx = '0;
  logic [4:0] buf_raddr = '0;
  logic       rd_empty, rd_cm, rd_last, rd_crc_err, rd_abort, rx_frame, rx_busy;
  logic [15:0] rd_len;
  logic [7:0] buf_rdata;

  hdlc_rx_ring #(.NUM_DESC(NUM), .BUF_BYTES(BUF)) i_hdlc_rx_ring (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .sw_arm(sw_arm), .sw_idx(sw_idx), .sw_cm(sw_cm), .rd_idx(rd_idx),
    .rd_empty(rd_empty), .rd_cm(rd_cm), .rd_last(rd_last), .rd_crc_err(rd_crc_err),
    .rd_abort(rd_abort), .rd_len(rd_len), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .rx_frame(rx_frame), .rx_busy(rx_busy)
  );

  int nchk = 0, nfail = 0, nframes = 0, nbusy = 0, exp_frames = 0, ptr = 0;
  bit done = 0;
  logic [7:0] pl [0:31];
  logic [7:0] fr [0:63];
  int fn;
  bit bad;

  always @(negedge clk) begin
    if (rx_frame) nframes++;
    if (rx_busy) nbusy++;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] b, input bit esc);
    if (esc || b == 8'h7E || b == 8'h7D) begin put(8'h7D); put(b ^ 8'h20); end
    else put(b);
  endtask

  task automatic arm(input int idx, input bit cm);
    sw_arm = 1'b1; sw_idx = 2'(idx); sw_cm = cm;
    @(negedge clk);
    sw_arm = 1'b0;
  endtask

  task automatic read_desc(input int idx);
    rd_idx = 2'(idx);
    @(negedge clk);
  endtask

  task automatic read_buf(input int a);
    buf_raddr = 5'(a);
    @(negedge clk);
  endtask

  // sends pl[0:plen-1] plus check bytes; fills fr/fn/bad
  task automatic send_frame(input int plen, input bit corrupt, input bit open_flag, input bit esc_all);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < plen; i++) begin c = crc_ref(c, pl[i]); fr[i] = pl[i]; end
    c = ~c;
    fr[plen] = c[7:0]; fr[plen+1] = c[15:8];
    fn = plen + 2;
    bad = corrupt;
    if (corrupt) fr[0] = fr[0] ^ 8'h04;
    if (open_flag) put(8'h7E);
    for (int i = 0; i < fn; i++) put_data(fr[i], esc_all || ($urandom % 8 == 0));
    put(8'h7E);
    repeat (3) @(negedge clk);
    exp_frames++;
  endtask

  task automatic check_frame(input int p, input bit cm_last);
    int k = (fn + BUF - 1) / BUF;
    chk(nframes == exp_frames, "R7 frame pulse count", nframes, exp_frames);
    for (int j = 0; j < k; j++) begin
      read_desc((p + j) % NUM);
      if (j < k - 1) begin
        chk(rd_empty == 1'b0, "R3 spilled empty", rd_empty, 0);
        chk(rd_last == 1'b0, "R3 spilled last", rd_last, 0);
        chk(rd_len == 16'(BUF), "R3 spilled len", rd_len, BUF);
      end else begin
        chk(rd_len == 16'(fn), "R6 frame len", rd_len, fn);
        chk(rd_last == 1'b1, "R6 last bit", rd_last, 1);
        chk(rd_crc_err == bad, "R5 crc err", rd_crc_err, bad);
        chk(rd_abort == 1'b0, "R9 abort clear", rd_abort, 0);
        chk(rd_empty == (cm_last && (fn % BUF != 0)), "R7 empty at close",
            rd_empty, (cm_last && (fn % BUF != 0)));
      end
    end
    for (int i = 0; i < fn; i++) begin
      read_buf(((p + i / BUF) % NUM) * BUF + (i % BUF));
      chk(buf_rdata == fr[i], "R6 R4 stored byte", buf_rdata, fr[i]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int dummy, k, plen;
    bit cm;
    dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    for (int i = 0; i < NUM; i++) begin
      read_desc(i);
      chk(rd_empty == 0 && rd_last == 0 && rd_len == 0, "R11 desc after reset", rd_empty, 0);
    end
    chk(rx_frame == 0 && rx_busy == 0, "R11 pulses low", rx_frame, 0);

    for (int i = 0; i < NUM; i++) arm(i, 1'b0);
    // R10 arm state
    read_desc(0);
    chk(rd_empty == 1 && rd_len == 0 && rd_last == 0, "R10 armed desc", rd_empty, 1);

    // R1 data before any flag is ignored
    put(8'h11); put(8'h22); repeat (3) @(negedge clk);
    chk(nframes == 0, "R1 no pulse in hunt", nframes, 0);
    read_desc(0);
    chk(rd_empty == 1 && rd_len == 0, "R1 desc untouched", rd_len, 0);

    // R4 R5 R6 directed frame with escaped payload
    pl[0] = 8'h41; pl[1] = 8'h7E; pl[2] = 8'h7D; pl[3] = 8'h05;
    send_frame(4, 1'b0, 1'b1, 1'b0);
    check_frame(0, 1'b0);
    // R8 shared flag, R4 every byte escaped (7D 41 -> 61)
    pl[0] = 8'h61;
    send_frame(1, 1'b0, 1'b0, 1'b1);
    check_frame(1, 1'b0);
    read_buf(1 * BUF);
    chk(buf_rdata == 8'h61, "R4 escaped 41 -> 61", buf_rdata, 8'h61);

    // R7 R3 exact fill with continuous mode, then short frame with continuous mode
    arm(2, 1'b1); arm(3, 1'b1);
    for (int i = 0; i < 6; i++) pl[i] = 8'(8'h30 + i);
    send_frame(6, 1'b0, 1'b0, 1'b0);
    check_frame(2, 1'b1);
    pl[0] = 8'h99;
    send_frame(1, 1'b1, 1'b0, 1'b0);
    check_frame(3, 1'b1);

    // R9 abort on descriptor 0
    arm(0, 1'b0);
    put(8'h10); put(8'h20); put(8'h7D); put(8'h7E);
    repeat (3) @(negedge clk);
    exp_frames++;
    chk(nframes == exp_frames, "R9 abort pulse", nframes, exp_frames);
    read_desc(0);
    chk(rd_abort == 1 && rd_crc_err == 0 && rd_last == 1 && rd_len == 2, "R9 abort desc", rd_len, 2);

    // R2 refused descriptor 1 (used, not re-armed)
    pl[0] = 8'hAA; pl[1] = 8'hBB;
    send_frame(2, 1'b0, 1'b0, 1'b0);
    exp_frames--;
    chk(nbusy == 1, "R2 busy pulse", nbusy, 1);
    chk(nframes == exp_frames, "R2 no frame pulse", nframes, exp_frames);
    read_desc(1);
    chk(rd_len == 3 && rd_last == 1, "R2 desc unchanged", rd_len, 3);
    arm(1, 1'b0);
    send_frame(2, 1'b0, 1'b0, 1'b0);
    check_frame(1, 1'b0);

    // R10 re-arm clears fields
    arm(2, 1'b1);
    read_desc(2);
    chk(rd_empty == 1 && rd_cm == 1 && rd_last == 0 && rd_len == 0 && rd_crc_err == 0,
        "R10 rearm clears", rd_len, 0);

    // random frames, R3 spill and ring wrap
    ptr = 2;
    for (int n = 0; n < 40; n++) begin
      plen = 1 + int'($urandom % 20);
      for (int i = 0; i < plen; i++) pl[i] = 8'($urandom);
      k = (plen + 2 + BUF - 1) / BUF;
      cm = 1'($urandom % 2);
      for (int j = 0; j < k; j++) arm((ptr + j) % NUM, (j == k - 1) ? cm : 1'b0);
      send_frame(plen, ($urandom % 4) == 0, 1'($urandom % 2), 1'b0);
      check_frame(ptr, cm);
      ptr = (ptr + k) % NUM;
    end

    done = 1;
    finish_run();
  end
endmodule